// File: doc/BRIEF.md
# Half-Bridge Dead-Time Interlock Controller

This block sits between a controller's two switch requests, one for the high side and one for the low side of a half bridge, and the two gate enable signals. It keeps the two enables from ever being high together. It holds back every turn-on by a programmable number of clock cycles. Turn-off edges go through with no added wait. If both sides are requested at once, both enables go low and neither side takes priority.

Several conditions force both enables to the safe low state:
- a disable input;
- an undervoltage flag on the input supply domain;
- an undervoltage flag on either output supply domain;
- a thermal shutdown.

Thermal shutdown is decided from a digital temperature code, with separate entry and exit thresholds. The request and disable pins may arrive asynchronously and each passes through a two-flop synchroniser. The undervoltage flags and the temperature code are treated as synchronous and act at the next clock edge. When a fault clears, the outputs follow the current requests again after a fresh dead-time count.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: When both synchronised requests are high, both gate outputs are low. The two gate outputs are never high in the same cycle.
- R2: A turn-on is delayed by the dead time. With a dead time of D clock cycles (D >= 1), a request raised at the pin with the other request low drives its gate high at the (3+D)th rising edge: two edges of synchronisation plus D counted cycles. The gate is still low at edge 2+D.
- R3: A turn-off has no dead-time wait. When a request falls at the pin, its gate goes low at the 3rd rising edge.
- R4: A dead-time setting of 0 behaves as 1. Between one gate falling and the other gate rising there is always at least one cycle with both gates low.
- R5: Withdrawing a request while its dead-time count runs cancels the pending turn-on and clears the count. A later request waits the full dead time again.
- R6: While the synchronised disable input is high, both gates are low. A disable change on the pin takes effect at the 3rd edge. After release, a held request turns its gate on at edge 3+D.
- R7: An input-side undervoltage flag forces both gates low at the next edge. After the flag clears, a held request turns its gate on at edge 1+D.
- R8: An undervoltage flag on either output supply domain (bit 0 high side, bit 1 low side) forces both gates low at the next edge. After it clears, a held request turns on at edge 1+D.
- R9: The temperature code is an unsigned count in degrees C. Thermal shutdown starts at the edge where the code is at or above 155 and stays active while the code is at or above 125. It ends at the edge where the code drops below 125. During shutdown both gates are low from that same edge on.
- R10: During and after reset both gates are low and the dead-time counts are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_hi_i | input | 1 | High-side switch request (asynchronous) |
| req_lo_i | input | 1 | Low-side switch request (asynchronous) |
| off_i | input | 1 | Disable, forces both gates low (asynchronous) |
| uv_in_i | input | 1 | Input-side supply undervoltage flag |
| uv_out_i | input | 2 | Output-side undervoltage flags, bit 0 high side, bit 1 low side |
| temp_i | input | TEMP_W | Die temperature code, degrees C |
| dt_cycles_i | input | DT_W | Dead time in clock cycles, 0 treated as 1 |
| gate_hi_o | output | 1 | High-side gate enable |
| gate_lo_o | output | 1 | Low-side gate enable |

## Verification
The bench builds the block with a 9-bit dead-time field, an 8-bit temperature code and trip points of 155 and 125. With these values the whole dead-time range can be reached, from the clamped zero setting up to the 511-cycle maximum. Both edges of the thermal hysteresis band can also be reached, including the codes just inside and just outside each threshold. The dead time is swept across 0, 1, 4, 5, 20 and 511 cycles. This shows that the turn-on delay tracks the setting exactly while turn-off latency stays fixed.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int N_SIDES = 2;

  typedef enum logic {
    SIDE_HI = 1'b0,
    SIDE_LO = 1'b1
  } side_e;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hb_thermal.sv
module hb_thermal #(
  parameter int TEMP_W   = 8,
  parameter int TRIP_ON  = 155,
  parameter int TRIP_OFF = 125
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              hot_o,
  output logic              hot_q_o
);
  localparam logic [TEMP_W-1:0] OnC  = TEMP_W'(TRIP_ON);
  localparam logic [TEMP_W-1:0] OffC = TEMP_W'(TRIP_OFF);

  logic hot_q, hot_d;

  // hysteresis: enter at >= ON, leave only below OFF
  always_comb hot_d = hot_q ? (temp_i >= OffC) : (temp_i >= OnC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hot_q <= 1'b0;
    else         hot_q <= hot_d;
  end

  // next state drives the kill path so the gates drop on the detecting edge
  assign hot_o   = hot_d;
  assign hot_q_o = hot_q;
endmodule

// File: rtl/hb_dt_chan.sv
module hb_dt_chan #(
  parameter int DT_W = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            want_i,
  input  logic            kill_i,
  input  logic            peer_on_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            gate_o
);
  logic [DT_W-1:0] cnt_q;
  logic            gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      cnt_q  <= '0;
    end else if (kill_i || !want_i) begin
      // turn-off and cancel are immediate
      gate_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!gate_q) begin
      if (cnt_q >= dt_i) begin
        if (!peer_on_i) gate_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl
  import hb_pkg::*;
#(
  parameter int DT_W     = 9,
  parameter int TEMP_W   = 8,
  parameter int TRIP_ON  = 155,
  parameter int TRIP_OFF = 125,
  parameter int SYNC_N   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_hi_i,
  input  logic              req_lo_i,
  input  logic              off_i,
  input  logic              uv_in_i,
  input  logic [1:0]        uv_out_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [DT_W-1:0]   dt_cycles_i,
  output logic              gate_hi_o,
  output logic              gate_lo_o
);
  localparam logic [DT_W-1:0] DtMin = DT_W'(1);

  logic [N_SIDES-1:0] req_s;
  logic               off_s;
  logic               hot, hot_q;
  logic               fault;
  logic [N_SIDES-1:0] want;
  logic [N_SIDES-1:0] gate;
  logic [DT_W-1:0]    dt_eff;

  hb_sync #(.W(N_SIDES + 1), .STAGES(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({off_i, req_lo_i, req_hi_i}),
    .q_o    ({off_s, req_s})
  );

  hb_thermal #(.TEMP_W(TEMP_W), .TRIP_ON(TRIP_ON), .TRIP_OFF(TRIP_OFF)) u_therm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .temp_i  (temp_i),
    .hot_o   (hot),
    .hot_q_o (hot_q)
  );

  assign fault  = off_s | uv_in_i | (|uv_out_i) | hot;
  assign dt_eff = (dt_cycles_i == '0) ? DtMin : dt_cycles_i;

  // simultaneous requests cancel each other
  assign want[SIDE_HI] = req_s[SIDE_HI] & ~req_s[SIDE_LO];
  assign want[SIDE_LO] = req_s[SIDE_LO] & ~req_s[SIDE_HI];

  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    hb_dt_chan #(.DT_W(DT_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .want_i    (want[s]),
      .kill_i    (fault),
      .peer_on_i (gate[N_SIDES-1-s]),
      .dt_i      (dt_eff),
      .gate_o    (gate[s])
    );
  end

  assign gate_hi_o = gate[SIDE_HI];
  assign gate_lo_o = gate[SIDE_LO];
endmodule

// File: rtl/hb_deadtime_ctrl_chk.sv
module hb_deadtime_ctrl_chk #(
  parameter int TEMP_W   = 8,
  parameter int TRIP_OFF = 125
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              gate_hi_i,
  input logic              gate_lo_i,
  input logic [1:0]        req_s_i,
  input logic [1:0]        want_i,
  input logic              off_s_i,
  input logic              uv_in_i,
  input logic [1:0]        uv_out_i,
  input logic [TEMP_W-1:0] temp_i,
  input logic              hot_q_i
);
  localparam logic [TEMP_W-1:0] OffC = TEMP_W'(TRIP_OFF);

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_hi_i && gate_lo_i)); // R1
  AST_BOTH_REQ_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&req_s_i) |=> (!gate_hi_i && !gate_lo_i)); // R1
  AST_RISE_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_hi_i) |-> $past(want_i[0])); // R2
  AST_FAST_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !want_i[0] |=> !gate_hi_i); // R3
  AST_GAP_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_hi_i) |-> !$past(gate_lo_i)); // R4
  AST_GAP_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_lo_i) |-> !$past(gate_hi_i)); // R4
  AST_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_s_i |=> (!gate_hi_i && !gate_lo_i)); // R6
  AST_UV_IN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_in_i |=> (!gate_hi_i && !gate_lo_i)); // R7
  AST_UV_OUT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|uv_out_i) |=> (!gate_hi_i && !gate_lo_i)); // R8
  AST_HOT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hot_q_i |-> (!gate_hi_i && !gate_lo_i)); // R9
  AST_HOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hot_q_i && temp_i >= OffC) |=> hot_q_i); // R9
endmodule

bind hb_deadtime_ctrl hb_deadtime_ctrl_chk #(.TEMP_W(TEMP_W), .TRIP_OFF(TRIP_OFF)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .gate_hi_i (gate_hi_o),
  .gate_lo_i (gate_lo_o),
  .req_s_i   (req_s),
  .want_i    (want),
  .off_s_i   (off_s),
  .uv_in_i   (uv_in_i),
  .uv_out_i  (uv_out_i),
  .temp_i    (temp_i),
  .hot_q_i   (hot_q)
);

// File: tb/hb_deadtime_ctrl_test.sv
`timescale 1ns/1ps
module hb_deadtime_ctrl_test;
  localparam int DT_W   = 9;
  localparam int TEMP_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_hi = 1'b0, req_lo = 1'b0, off = 1'b0, uv_in = 1'b0;
  logic [1:0] uv_out = 2'b00;
  logic [TEMP_W-1:0] temp = 8'd25;
  logic [DT_W-1:0] dt = 9'd4;
  logic gate_hi, gate_lo;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hb_deadtime_ctrl #(.DT_W(DT_W), .TEMP_W(TEMP_W), .TRIP_ON(155), .TRIP_OFF(125)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_hi_i(req_hi), .req_lo_i(req_lo), .off_i(off),
    .uv_in_i(uv_in), .uv_out_i(uv_out), .temp_i(temp), .dt_cycles_i(dt),
    .gate_hi_o(gate_hi), .gate_lo_o(gate_lo)
  );

  task automatic check(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet();
    req_hi = 0; req_lo = 0; off = 0; uv_in = 0; uv_out = 2'b00; temp = 8'd25;
    idle(6);
  endtask

  function automatic int deff(int d);
    return (d == 0) ? 1 : d;
  endfunction

  task automatic t_reset();
    req_hi = 1;
    idle(5);
    check("R10 hi in reset", gate_hi, 1'b0);
    check("R10 lo in reset", gate_lo, 1'b0);
    req_hi = 0;
    rst_n = 1;
    idle(4);
    check("R10 hi after reset", gate_hi, 1'b0);
    check("R10 lo after reset", gate_lo, 1'b0);
  endtask

  task automatic t_turn_on(int d_set, bit lo_side);
    int d = deff(d_set);
    quiet();
    dt = DT_W'(d_set);
    if (lo_side) req_lo = 1; else req_hi = 1;
    idle(2 + d);
    check("R2 still waiting", lo_side ? gate_lo : gate_hi, 1'b0);
    idle(1);
    check(d_set == 0 ? "R4 clamp on" : "R2 on after dead time", lo_side ? gate_lo : gate_hi, 1'b1);
    check("R1 other side low", lo_side ? gate_hi : gate_lo, 1'b0);
  endtask

  task automatic t_handover(int d_set);
    int d = deff(d_set);
    t_turn_on(d_set, 1'b0);
    req_hi = 0; req_lo = 1;
    idle(2);
    check("R3 hi before sync", gate_hi, 1'b1);
    idle(1);
    check("R3 hi off at edge 3", gate_hi, 1'b0);
    check("R4 lo not yet", gate_lo, 1'b0);
    idle(d - 1);
    check("R4 lo held in dead time", gate_lo, 1'b0);
    idle(1);
    check("R4 lo on after gap", gate_lo, 1'b1);
  endtask

  task automatic t_both();
    t_turn_on(5, 1'b0);
    req_lo = 1;
    idle(3);
    check("R1 hi low on both", gate_hi, 1'b0);
    idle(10);
    check("R1 hi stays low", gate_hi, 1'b0);
    check("R1 lo stays low", gate_lo, 1'b0);
  endtask

  task automatic t_cancel();
    quiet();
    dt = 9'd20;
    req_hi = 1;
    idle(18);
    req_hi = 0;
    idle(6);
    check("R5 cancelled pulse", gate_hi, 1'b0);
    req_hi = 1;
    idle(22);
    check("R5 full recount", gate_hi, 1'b0);
    idle(1);
    check("R5 on after recount", gate_hi, 1'b1);
  endtask

  task automatic t_disable();
    t_turn_on(4, 1'b0);
    off = 1;
    idle(2);
    check("R6 before sync", gate_hi, 1'b1);
    idle(1);
    check("R6 disabled", gate_hi, 1'b0);
    idle(5);
    check("R6 held disabled", gate_hi, 1'b0);
    off = 0;
    idle(6);
    check("R6 release waits", gate_hi, 1'b0);
    idle(1);
    check("R6 release on", gate_hi, 1'b1);
  endtask

  task automatic t_uv_in();
    t_turn_on(5, 1'b1);
    uv_in = 1;
    idle(1);
    check("R7 lo off", gate_lo, 1'b0);
    check("R7 hi off", gate_hi, 1'b0);
    idle(4);
    uv_in = 0;
    idle(5);
    check("R7 restore waits", gate_lo, 1'b0);
    idle(1);
    check("R7 restore on", gate_lo, 1'b1);
  endtask

  task automatic t_uv_out();
    t_turn_on(4, 1'b1);
    uv_out = 2'b01;
    idle(1);
    check("R8 hi-side flag kills lo", gate_lo, 1'b0);
    uv_out = 2'b00;
    idle(4);
    check("R8 restore waits", gate_lo, 1'b0);
    idle(1);
    check("R8 restore on", gate_lo, 1'b1);
    uv_out = 2'b10;
    idle(1);
    check("R8 lo-side flag kills lo", gate_lo, 1'b0);
    uv_out = 2'b00;
    idle(6);
  endtask

  task automatic t_thermal();
    t_turn_on(4, 1'b0);
    temp = 8'd154;
    idle(5);
    check("R9 below trip", gate_hi, 1'b1);
    temp = 8'd155;
    idle(1);
    check("R9 trip", gate_hi, 1'b0);
    temp = 8'd140;
    idle(9);
    check("R9 hold in band", gate_hi, 1'b0);
    temp = 8'd125;
    idle(9);
    check("R9 hold at exit edge", gate_hi, 1'b0);
    temp = 8'd124;
    idle(4);
    check("R9 exit waits", gate_hi, 1'b0);
    idle(1);
    check("R9 exit on", gate_hi, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R10: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_turn_on(1, 1'b0);
    t_turn_on(0, 1'b1);
    t_turn_on(20, 1'b0);
    t_turn_on(511, 1'b1);
    t_handover(5);
    t_handover(0);
    t_both();
    t_cancel();
    t_disable();
    t_uv_in();
    t_uv_out();
    t_thermal();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule